// File: doc/BRIEF.md
# Multi-lane oversampling sum accumulator

The block takes a group of converter samples, one per lane, which arrive together with a single valid strobe in the system clock domain. Each lane adds up a fixed number of consecutive samples. When the last sample of a group arrives, the block copies the sum into an output register and raises a ready flag. The output keeps the upper bits of the wide sum, so each output field has the same width as an input sample. All lanes are counted and summed in lockstep, because every lane is sampled at the same instant.

A package enum selects one of two variants. The phonon-style variant has four 14-bit lanes and sums groups of 16 samples. The charge-style variant has two 16-bit lanes and sums groups of 2 samples. The ready flag stays high for a set number of cycles, and the output bus holds its value until the next group completes. A consumer may therefore poll the bus from the same clock or from a slower one.

Top module: `oversample_sum`

## Requirements
- R1: While the active-low reset rst_ni is low, and right after it is released, sum_rdy_o is 0 and sum_bus_o is all zeros. A reset asserted in the middle of a group discards the partial sums and the sample count.
- R2: Lane i of both buses occupies bits [i*SAMPLE_W +: SAMPLE_W]. Lane 0 is in the least significant field. Each lane is summed only from its own input field.
- R3: Each output field equals the bits [SAMPLE_W+log2(SUM_LEN)-1 : log2(SUM_LEN)] of the exact sum of that lane's SUM_LEN samples, which is floor(sum / SUM_LEN). A group whose samples are all at full scale gives a full-scale output, with no wrap-around.
- R4: Only cycles with smp_valid_i = 1 count towards a group. Cycles with smp_valid_i = 0 leave the count and the partial sums unchanged, whatever is on smp_bus_i. The first result after reset needs SUM_LEN valid samples.
- R5: sum_rdy_o rises in the cycle that follows the edge at which the SUM_LEN-th valid sample of a group is taken. It then stays high for exactly RDY_HOLD cycles, unless another group completes during that time.
- R6: sum_bus_o changes only at the edge that completes a group. It holds its value across idle cycles and after sum_rdy_o falls.
- R7: The sample that completes a group also starts the next group from zero. If another group completes while sum_rdy_o is still high, sum_bus_o takes the new result and the ready hold restarts at RDY_HOLD cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| smp_valid_i | input | 1 | One group of lane samples is present this cycle |
| smp_bus_i | input | NUM_CH*SAMPLE_W | Packed lane samples, unsigned, lane 0 in the LSBs |
| sum_bus_o | output | NUM_CH*SAMPLE_W | Packed scaled sums, lane 0 in the LSBs |
| sum_rdy_o | output | 1 | A new result is on sum_bus_o; stays high RDY_HOLD cycles |

## Verification
The final sample of a group does two jobs in the same cycle. It closes the group into the output register, and it restarts the accumulators for the next group. A second completion can also arrive while the ready flag from the first is still high. The bench drives two groups back to back with valid high on every cycle, so each of these events lands on the same edge as the other job. It then checks two things. The second result must match its own samples exactly, with nothing carried over from the first group. The ready flag must stay high without a gap for 16 + RDY_HOLD cycles in a row.

// File: rtl/osum_pkg.sv
package osum_pkg;

  typedef enum logic {
    VAR_PHONON = 1'b0,
    VAR_CHARGE = 1'b1
  } variant_e;

  function automatic int lane_count(variant_e v);
    return (v == VAR_CHARGE) ? 2 : 4;
  endfunction

  function automatic int lane_width(variant_e v);
    return (v == VAR_CHARGE) ? 16 : 14;
  endfunction

  function automatic int group_len(variant_e v);
    return (v == VAR_CHARGE) ? 2 : 16;
  endfunction

endpackage

// File: rtl/osum_seq.sv
module osum_seq #(
  parameter int SUM_LEN  = 16,
  parameter int RDY_HOLD = 20
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic valid_i,
  output logic last_o,
  output logic rdy_o
);

  localparam int CNT_W  = (SUM_LEN > 2) ? $clog2(SUM_LEN) : 1;
  localparam int HOLD_W = $clog2(RDY_HOLD + 1);

  logic [CNT_W-1:0]  cnt_q;
  logic [HOLD_W-1:0] hold_q;

  assign last_o = valid_i && (cnt_q == CNT_W'(SUM_LEN - 1));
  assign rdy_o  = (hold_q != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (valid_i) begin
      cnt_q <= last_o ? '0 : cnt_q + 1'b1;
    end
  end

  // ready is held for a fixed window; a new completion reloads it
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q <= '0;
    end else if (last_o) begin
      hold_q <= HOLD_W'(RDY_HOLD);
    end else if (hold_q != '0) begin
      hold_q <= hold_q - 1'b1;
    end
  end

  AST_RDY_AFTER_LAST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_o |=> rdy_o); // R5
  AST_RDY_RISE_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rdy_o) |-> $past(last_o)); // R5
  AST_CNT_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(cnt_q)); // R4

endmodule

// File: rtl/osum_lane.sv
module osum_lane #(
  parameter int SAMPLE_W = 14,
  parameter int SUM_LEN  = 16
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                valid_i,
  input  logic                last_i,
  input  logic [SAMPLE_W-1:0] sample_i,
  output logic [SAMPLE_W-1:0] avg_o
);

  localparam int SHIFT = $clog2(SUM_LEN);
  localparam int ACC_W = SAMPLE_W + SHIFT;

  logic [ACC_W-1:0]    acc_q;
  logic [ACC_W-1:0]    sum_full;
  logic [SAMPLE_W-1:0] avg_q;

  assign sum_full = acc_q + ACC_W'(sample_i);
  assign avg_o    = avg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q <= '0;
      avg_q <= '0;
    end else if (valid_i) begin
      if (last_i) begin
        acc_q <= '0;  // completing sample also opens the next group
        avg_q <= sum_full[ACC_W-1 -: SAMPLE_W];
      end else begin
        acc_q <= sum_full;
      end
    end
  end

  AST_ACC_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(acc_q)); // R4
  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !last_i) |=> (acc_q >= $past(acc_q))); // R3
  AST_AVG_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(valid_i && last_i) |=> $stable(avg_q)); // R6

endmodule

// File: rtl/oversample_sum.sv
module oversample_sum
  import osum_pkg::*;
#(
  parameter variant_e VARIANT  = VAR_PHONON,
  parameter int       RDY_HOLD = 20,
  localparam int      NUM_CH   = lane_count(VARIANT),
  localparam int      SAMPLE_W = lane_width(VARIANT),
  localparam int      SUM_LEN  = group_len(VARIANT),
  localparam int      BUS_W    = NUM_CH * SAMPLE_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             smp_valid_i,
  input  logic [BUS_W-1:0] smp_bus_i,
  output logic [BUS_W-1:0] sum_bus_o,
  output logic             sum_rdy_o
);

  logic grp_last;

  osum_seq #(
    .SUM_LEN (SUM_LEN),
    .RDY_HOLD(RDY_HOLD)
  ) u_seq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .valid_i(smp_valid_i),
    .last_o (grp_last),
    .rdy_o  (sum_rdy_o)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_lane
    osum_lane #(
      .SAMPLE_W(SAMPLE_W),
      .SUM_LEN (SUM_LEN)
    ) u_lane (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .valid_i (smp_valid_i),
      .last_i  (grp_last),
      .sample_i(smp_bus_i[g*SAMPLE_W +: SAMPLE_W]),
      .avg_o   (sum_bus_o[g*SAMPLE_W +: SAMPLE_W])
    );
  end

  AST_BUS_ONLY_ON_LAST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !grp_last |=> $stable(sum_bus_o)); // R6
  AST_LAST_NEEDS_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grp_last |-> smp_valid_i); // R4

endmodule

// File: tb/sim_oversample_sum.sv
module sim_oversample_sum;

  localparam int NCH  = 4;
  localparam int W    = 14;
  localparam int N    = 16;
  localparam int HOLD = 20;
  localparam int BUS  = NCH * W;
  localparam int NV   = 6;

  // {base[25:12], step[11:4], gap[3:0]}
  localparam logic [25:0] VEC [NV] = '{
    {14'd0,     8'd0,   4'd0},
    {14'd100,   8'd1,   4'd0},
    {14'd16000, 8'd37,  4'd2},
    {14'd5000,  8'd255, 4'd1},
    {14'd16383, 8'd0,   4'd3},
    {14'd8191,  8'd200, 4'd0}
  };

  logic           clk = 1'b0;
  logic           rst_n;
  logic           vld;
  logic [BUS-1:0] din;
  logic [BUS-1:0] dout;
  logic           rdy;
  int             checks = 0;
  int             fails  = 0;

  always #10 clk = ~clk;

  oversample_sum #(.RDY_HOLD(HOLD)) u0 (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .smp_valid_i(vld),
    .smp_bus_i  (din),
    .sum_bus_o  (dout),
    .sum_rdy_o  (rdy)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic step(input logic v, input logic [BUS-1:0] d);
    vld = v;
    din = d;
    @(negedge clk);
  endtask

  function automatic logic [W-1:0] smp(int c, int k, logic [13:0] b, logic [7:0] s);
    return W'(int'(b) + c * 1031 + k * int'(s));
  endfunction

  // one full group; returns expected bus, checks ready low before last if asked
  task automatic run_group(input logic [13:0] b, input logic [7:0] s, input int gap,
                           input bit first, output logic [BUS-1:0] exp);
    int sums [NCH];
    logic [BUS-1:0] d;
    for (int c = 0; c < NCH; c++) sums[c] = 0;
    for (int k = 0; k < N; k++) begin
      for (int c = 0; c < NCH; c++) begin
        d[c*W +: W] = smp(c, k, b, s);
        sums[c] += int'(d[c*W +: W]);
      end
      step(1'b1, d);
      if (k == N - 2 && first) chk("R4 no ready before full group", 64'(rdy), 64'd0);
      if (k < N - 1)
        for (int i = 0; i < gap; i++) step(1'b0, ~d);
    end
    for (int c = 0; c < NCH; c++) exp[c*W +: W] = W'(sums[c] / N);
  endtask

  task automatic const_group(input logic [W-1:0] x);
    for (int k = 0; k < N; k++) step(1'b1, {NCH{x}});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [BUS-1:0] exp;
    int hi;
    rst_n = 1'b0;
    vld   = 1'b0;
    din   = '0;
    repeat (3) @(negedge clk);
    chk("R1 ready in reset", 64'(rdy), 64'd0);
    chk("R1 bus in reset", 64'(dout), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 ready after release", 64'(rdy), 64'd0);

    // table walk: lane-distinct ramps with idle gaps (R2 R3 R4 R5)
    for (int v = 0; v < NV; v++) begin
      run_group(VEC[v][25:12], VEC[v][11:4], int'(VEC[v][3:0]), v == 0, exp);
      chk("R5 ready after group", 64'(rdy), 64'd1);
      chk("R2 R3 lane sums", 64'(dout), 64'(exp));
    end

    // full scale: no wrap (R3), hold length (R5), bus stable (R6)
    repeat (HOLD + 2) step(1'b0, '0);
    const_group(14'h3FFF);
    chk("R3 full scale", 64'(dout), 64'(56'hFF_FFFF_FFFF_FFFF));
    hi = 1;
    for (int i = 0; i < HOLD + 4; i++) begin
      step(1'b0, 56'h12_3456_789A_BCDE);
      if (rdy) hi++;
    end
    chk("R5 ready hold length", 64'(hi), 64'(HOLD));
    chk("R6 bus stable when idle", 64'(dout), 64'(56'hFF_FFFF_FFFF_FFFF));

    // back-to-back groups: restart and hold reload (R7)
    const_group(14'd40);
    chk("R7 first of pair", 64'(dout), 64'({NCH{14'd40}}));
    hi = 1;
    for (int k = 0; k < N; k++) begin
      step(1'b1, {NCH{14'd80}});
      if (rdy) hi++;
    end
    chk("R7 second group clean", 64'(dout), 64'({NCH{14'd80}}));
    for (int i = 0; i < HOLD + 4; i++) begin
      step(1'b0, '0);
      if (rdy) hi++;
    end
    chk("R7 ready hold reloaded", 64'(hi), 64'(N + HOLD));

    // reset mid-group discards partial state (R1 R4)
    for (int k = 0; k < 7; k++) step(1'b1, {NCH{14'd500}});
    vld   = 1'b0;
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1 ready on mid reset", 64'(rdy), 64'd0);
    chk("R1 bus on mid reset", 64'(dout), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    for (int k = 0; k < N - 1; k++) step(1'b1, {NCH{14'd900}});
    chk("R4 count restarted", 64'(rdy), 64'd0);
    step(1'b1, {NCH{14'd900}});
    chk("R1 R4 fresh group", 64'(dout), 64'({NCH{14'd900}}));
    chk("R5 ready fresh group", 64'(rdy), 64'd1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule